// File: doc/BRIEF.md
# Digital Potentiometer Wiper Register Controller

This block holds the digital state of a 1024-position potentiometer. It keeps a 10-bit wiper position register and a bank of four 10-bit data registers that stand in for nonvolatile storage. The wiper position is decoded into a registered one-hot select for 1024 tap switches, so exactly one switch along the resistor chain is ever enabled. Position 0 is the low-end terminal and position 1023 is the high-end terminal.

The host drives a valid/ready command port. A command can write the wiper directly, read the wiper back, read or write any data register, or move a value between a data register and the wiper in either direction. A write into a data register models a slow nonvolatile program. It raises a busy flag for a parameter-defined number of cycles, and the block rejects every command that arrives in that window. Two resets exist. `rst_n` returns the whole block, data registers included, to its initial state. `pwrup_n` models a power cycle: the data registers keep their contents and the wiper reloads from data register 0.

Top module: `dpot_wiper_ctrl`

## Requirements
- R1: `tap_sel` always has exactly one bit set, and that bit's index equals the wiper position. Position 0 selects bit 0 (low end) and position 1023 selects bit 1023 (high end).
- R2: `tap_sel` is registered. It reflects a new wiper position one clock edge after `wiper_pos` changes.
- R3: An accepted op 0 (write wiper) with the block not busy loads `cmd_data` into `wiper_pos` at the accepting edge.
- R4: An accepted op 1 (read wiper) or op 3 (read data register `cmd_idx`) with the block not busy raises `rsp_valid` for exactly one cycle after the accepting edge. `rsp_data` carries the value held before that edge.
- R5: An accepted op 2 (write data register `cmd_idx` with `cmd_data`) stores the value. `nv_busy` is then high for exactly NV_CYCLES cycles, starting in the cycle after the accepting edge.
- R6: Op 4 copies data register `cmd_idx` into the wiper. Op 5 copies the wiper into data register `cmd_idx` and starts the busy window of R5.
- R7: A command accepted while `nv_busy` is high, or one carrying op 6 or 7, gives a one-cycle `cmd_err` pulse after the accepting edge. It changes no register and produces no `rsp_valid`.
- R8: While `pwrup_n` is low, `cmd_ready` is low, the wiper loads data register 0 on every edge, and `nv_busy` clears. The data registers keep their contents.
- R9: Asynchronous `rst_n` low sets every data register to DR_INIT, sets the wiper to 0 with `tap_sel` bit 0, and clears `nv_busy`, `rsp_valid` and `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low full reset, including data registers |
| pwrup_n | input | 1 | Active-low power-up: wiper reloads from data register 0 |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken (low during power-up) |
| cmd_op | input | 3 | Operation code 0..5; 6 and 7 are illegal |
| cmd_idx | input | 2 | Data register index |
| cmd_data | input | 10 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | 10 | Read response value |
| cmd_err | output | 1 | One-cycle rejection pulse |
| nv_busy | output | 1 | Nonvolatile write window active |
| wiper_pos | output | 10 | Current wiper position |
| tap_sel | output | 1024 | One-hot tap switch enables |

## Verification
The bench drives the two terminal positions. A decoder with an off-by-one or a truncated compare would light the wrong end tap or no tap at all. It sends commands during the busy window, including a read and a wiper write. A design that let these through would change the wiper or return data without the error pulse. It counts the busy window cycle by cycle, which exposes a counter that runs one cycle short or long. It also asserts `pwrup_n` both after data register 0 has been rewritten and during a busy window. A design that wiped the data registers, reloaded the wiper from the wrong register, or left busy set would all diverge from the reference model.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_WR_WIPER    = 3'd0,
    OP_RD_WIPER    = 3'd1,
    OP_WR_DR       = 3'd2,
    OP_RD_DR       = 3'd3,
    OP_DR_TO_WIPER = 3'd4,
    OP_WIPER_TO_DR = 3'd5
  } op_e;

  localparam logic [OP_W-1:0] OP_LAST = 3'd5;
endpackage

// File: rtl/dpot_nv_bank.sv
module dpot_nv_bank #(
  parameter int unsigned POS_W     = 10,
  parameter int unsigned NUM_DR    = 4,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned NV_CYCLES = 8,
  parameter logic [POS_W-1:0] DR_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_busy,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [POS_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [POS_W-1:0] rd_data,
  output logic [POS_W-1:0] dr0_data,
  output logic             busy
);
  localparam int unsigned CW = $clog2(NV_CYCLES + 1);

  logic [POS_W-1:0] dr_q [NUM_DR];
  logic [CW-1:0]    cnt_q, cnt_d;

  for (genvar g = 0; g < NUM_DR; g++) begin : g_dr
    logic ld;
    assign ld = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  dr_q[g] <= DR_INIT;
      else if (ld) dr_q[g] <= wr_data;
    end
  end

  assign rd_data  = dr_q[rd_idx];
  assign dr0_data = dr_q[0];

  always_comb begin
    cnt_d = cnt_q;
    if (clr_busy)           cnt_d = '0;
    else if (wr_en)         cnt_d = CW'(NV_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dpot_wiper_reg.sv
module dpot_wiper_reg #(
  parameter int unsigned POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [POS_W-1:0] load_data,
  output logic [POS_W-1:0] wiper
);
  logic [POS_W-1:0] wiper_d;

  always_comb begin
    wiper_d = wiper;
    if (load_en) wiper_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wiper <= '0;
    else        wiper <= wiper_d;
  end
endmodule

// File: rtl/dpot_tap_decode.sv
module dpot_tap_decode #(
  parameter int unsigned POS_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [POS_W-1:0]        pos,
  output logic [(1<<POS_W)-1:0]   tap_q
);
  localparam int unsigned TAPS = 1 << POS_W;

  logic [TAPS-1:0] tap_d;

  always_comb begin
    for (int i = 0; i < TAPS; i++) begin
      tap_d[i] = (pos == POS_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= TAPS'(1);
    else        tap_q <= tap_d;
  end
endmodule

// File: rtl/dpot_wiper_ctrl.sv
module dpot_wiper_ctrl
  import dpot_pkg::*;
#(
  parameter int unsigned POS_W     = 10,
  parameter int unsigned NUM_DR    = 4,
  parameter int unsigned IDX_W     = $clog2(NUM_DR),
  parameter int unsigned NV_CYCLES = 1250000,
  parameter logic [POS_W-1:0] DR_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwrup_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [OP_W-1:0]       cmd_op,
  input  logic [IDX_W-1:0]      cmd_idx,
  input  logic [POS_W-1:0]      cmd_data,
  output logic                  rsp_valid,
  output logic [POS_W-1:0]      rsp_data,
  output logic                  cmd_err,
  output logic                  nv_busy,
  output logic [POS_W-1:0]      wiper_pos,
  output logic [(1<<POS_W)-1:0] tap_sel
);
  logic             accept, exec;
  logic             wp_ld;
  logic [POS_W-1:0] wp_ld_data;
  logic             nv_wr;
  logic [POS_W-1:0] nv_wr_data;
  logic [POS_W-1:0] dr_rd, dr0;
  logic             rv_d, err_d;
  logic [POS_W-1:0] rd_d;
  logic             rv_q, err_q;
  logic [POS_W-1:0] rd_q;

  assign cmd_ready = pwrup_n;
  assign accept    = cmd_valid && cmd_ready;
  assign exec      = accept && !nv_busy && (cmd_op <= OP_LAST);

  always_comb begin
    wp_ld      = 1'b0;
    wp_ld_data = cmd_data;
    nv_wr      = 1'b0;
    nv_wr_data = cmd_data;
    rv_d       = 1'b0;
    rd_d       = rd_q;
    err_d      = accept && !exec;
    if (!pwrup_n) begin
      wp_ld      = 1'b1;
      wp_ld_data = dr0;
    end else if (exec) begin
      unique case (op_e'(cmd_op))
        OP_WR_WIPER:    wp_ld = 1'b1;
        OP_RD_WIPER:    begin rv_d = 1'b1; rd_d = wiper_pos; end
        OP_WR_DR:       nv_wr = 1'b1;
        OP_RD_DR:       begin rv_d = 1'b1; rd_d = dr_rd; end
        OP_DR_TO_WIPER: begin wp_ld = 1'b1; wp_ld_data = dr_rd; end
        OP_WIPER_TO_DR: begin nv_wr = 1'b1; nv_wr_data = wiper_pos; end
        default:        ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      err_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      rv_q  <= rv_d;
      err_q <= err_d;
      if (rv_d) rd_q <= rd_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
  assign cmd_err   = err_q;

  dpot_nv_bank #(
    .POS_W(POS_W), .NUM_DR(NUM_DR), .IDX_W(IDX_W),
    .NV_CYCLES(NV_CYCLES), .DR_INIT(DR_INIT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .clr_busy(!pwrup_n),
    .wr_en(nv_wr), .wr_idx(cmd_idx), .wr_data(nv_wr_data),
    .rd_idx(cmd_idx), .rd_data(dr_rd), .dr0_data(dr0), .busy(nv_busy)
  );

  dpot_wiper_reg #(.POS_W(POS_W)) u_wiper (
    .clk(clk), .rst_n(rst_n), .load_en(wp_ld),
    .load_data(wp_ld_data), .wiper(wiper_pos)
  );

  dpot_tap_decode #(.POS_W(POS_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .pos(wiper_pos), .tap_q(tap_sel)
  );
endmodule

// File: rtl/dpot_wiper_ctrl_chk.sv
module dpot_wiper_ctrl_chk #(
  parameter int unsigned POS_W = 10,
  parameter int unsigned OP_W  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pwrup_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [OP_W-1:0]       cmd_op,
  input logic                  rsp_valid,
  input logic                  cmd_err,
  input logic                  nv_busy,
  input logic [POS_W-1:0]      wiper_pos,
  input logic [(1<<POS_W)-1:0] tap_sel
);
  // R1
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  // R2
  tap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tap_sel[$past(wiper_pos)]);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_busy) |-> $past(cmd_valid && cmd_ready && (cmd_op == 3'd2 || cmd_op == 3'd5)));

  // R7
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && nv_busy) |=> (cmd_err && !rsp_valid && $stable(wiper_pos)));

  // R7
  illegal_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op > 3'd5) |=> (cmd_err && !rsp_valid));

  // R4
  rsp_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && cmd_err));

  // R8
  pwrup_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrup_n |-> !cmd_ready);

  // R8
  pwrup_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrup_n |=> !nv_busy);
endmodule

bind dpot_wiper_ctrl dpot_wiper_ctrl_chk #(.POS_W(POS_W), .OP_W(dpot_pkg::OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwrup_n(pwrup_n), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .rsp_valid(rsp_valid),
  .cmd_err(cmd_err), .nv_busy(nv_busy), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
);

// File: tb/tb_dpot_wiper_ctrl.sv
`timescale 1ns/1ps
module tb_dpot_wiper_ctrl;
  localparam int NV   = 6;
  localparam int TAPS = 1024;
  localparam logic [9:0] INIT = 10'h155;

  logic clk = 1'b0;
  logic rst_n, pwrup_n, cmd_valid;
  logic [2:0] cmd_op;
  logic [1:0] cmd_idx;
  logic [9:0] cmd_data;
  logic cmd_ready, rsp_valid, cmd_err, nv_busy;
  logic [9:0] rsp_data, wiper_pos;
  logic [TAPS-1:0] tap_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dpot_wiper_ctrl #(.NV_CYCLES(NV), .DR_INIT(INIT)) dut (
    .clk(clk), .rst_n(rst_n), .pwrup_n(pwrup_n), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cmd_err(cmd_err),
    .nv_busy(nv_busy), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_wiper, m_tap, m_cnt, m_rd;
  bit m_rv, m_err;
  int m_dr[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wiper = 0; m_tap = 0; m_cnt = 0; m_rv = 0; m_err = 0; m_rd = 0;
      for (int k = 0; k < 4; k++) m_dr[k] = INIT;
    end else begin
      int b, ow;
      b = m_cnt; ow = m_wiper;
      m_tap = m_wiper; m_rv = 0; m_err = 0;
      if (!pwrup_n) begin
        m_wiper = m_dr[0]; m_cnt = 0;
      end else begin
        if (m_cnt > 0) m_cnt--;
        if (cmd_valid) begin
          if (b > 0 || cmd_op > 5) m_err = 1;
          else case (cmd_op)
            0: m_wiper = cmd_data;
            1: begin m_rv = 1; m_rd = ow; end
            2: begin m_dr[cmd_idx] = cmd_data; m_cnt = NV; end
            3: begin m_rv = 1; m_rd = m_dr[cmd_idx]; end
            4: m_wiper = m_dr[cmd_idx];
            default: begin m_dr[cmd_idx] = ow; m_cnt = NV; end
          endcase
        end
      end
    end
  end

  always @(posedge clk) begin
    #3;
    chk(wiper_pos == 10'(m_wiper), "R3 wiper model", wiper_pos, m_wiper);
    chk(tap_sel == (TAPS'(1) << m_tap), "R1 R2 tap_sel model", $clog2(tap_sel), m_tap);
    chk(nv_busy == (m_cnt > 0), "R5 busy model", nv_busy, m_cnt > 0);
    chk(rsp_valid == m_rv, "R4 rsp_valid model", rsp_valid, m_rv);
    if (m_rv) chk(rsp_data == 10'(m_rd), "R4 rsp_data model", rsp_data, m_rd);
    chk(cmd_err == m_err, "R7 err model", cmd_err, m_err);
    chk(cmd_ready == pwrup_n, "R8 ready model", cmd_ready, pwrup_n);
  end

  task automatic cmd(input int op, input int idx, input int data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_idx = 2'(idx); cmd_data = 10'(data);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (nv_busy) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; pwrup_n = 1'b0; cmd_valid = 1'b0;
    cmd_op = '0; cmd_idx = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(wiper_pos == 0 && tap_sel[0] && !nv_busy && !cmd_err && !rsp_valid,
        "R9 reset state", wiper_pos, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8 power-up loads data register 0
    chk(wiper_pos == INIT, "R8 power-up load", wiper_pos, INIT);
    chk(!cmd_ready, "R8 ready low in power-up", cmd_ready, 0);
    pwrup_n = 1'b1;

    cmd(0, 0, 10'h3FF);
    chk(wiper_pos == 10'h3FF, "R3 direct write", wiper_pos, 10'h3FF);
    chk(tap_sel[INIT], "R2 tap lags one edge", tap_sel[INIT], 1);
    @(negedge clk);
    chk(tap_sel[1023] && $countones(tap_sel) == 1, "R1 high end tap", tap_sel[1023], 1);
    cmd(0, 0, 0);
    @(negedge clk);
    chk(tap_sel[0] && $countones(tap_sel) == 1, "R1 low end tap", tap_sel[0], 1);

    cmd(1, 0, 0);
    chk(rsp_valid && rsp_data == 0, "R4 read wiper", rsp_data, 0);
    @(negedge clk);
    chk(!rsp_valid, "R4 one-cycle strobe", rsp_valid, 0);

    cmd(2, 2, 10'h2AA);
    chk(nv_busy, "R5 busy after write", nv_busy, 1);
    cmd(0, 0, 10'h111);
    chk(cmd_err && wiper_pos == 0, "R7 reject while busy", wiper_pos, 0);
    cmd(3, 2, 0);
    chk(cmd_err && !rsp_valid, "R7 read rejected while busy", rsp_valid, 0);
    wait_idle();
    cmd(3, 2, 0);
    chk(rsp_valid && rsp_data == 10'h2AA, "R4 R5 read data register", rsp_data, 10'h2AA);

    cmd(4, 2, 0);
    chk(wiper_pos == 10'h2AA, "R6 register to wiper", wiper_pos, 10'h2AA);
    cmd(0, 0, 10'h0F0);
    cmd(5, 0, 0);
    wait_idle();
    cmd(3, 0, 0);
    chk(rsp_data == 10'h0F0, "R6 wiper to register", rsp_data, 10'h0F0);

    cmd(7, 1, 10'h123);
    chk(cmd_err && !rsp_valid && wiper_pos == 10'h0F0, "R7 illegal op", cmd_err, 1);
    cmd(6, 1, 10'h123);
    chk(cmd_err, "R7 illegal op 6", cmd_err, 1);

    cmd(2, 1, 10'h3C3);
    n = 0;
    while (nv_busy) begin n++; @(negedge clk); end
    chk(n == NV, "R5 busy length", n, NV);

    cmd(0, 0, 10'h001);
    pwrup_n = 1'b0;
    repeat (2) @(negedge clk);
    pwrup_n = 1'b1;
    chk(wiper_pos == 10'h0F0, "R8 reload from register 0", wiper_pos, 10'h0F0);
    cmd(3, 1, 0);
    chk(rsp_data == 10'h3C3, "R8 registers kept", rsp_data, 10'h3C3);

    cmd(2, 3, 10'h050);
    pwrup_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!nv_busy, "R8 power-up clears busy", nv_busy, 0);
    pwrup_n = 1'b1;

    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      pwrup_n = ($urandom_range(0, 49) != 0);
      cmd_valid = ($urandom_range(0, 2) != 0);
      cmd_op = 3'($urandom_range(0, 7));
      cmd_idx = 2'($urandom_range(0, 3));
      cmd_data = 10'($urandom_range(0, 1023));
    end
    @(negedge clk);
    cmd_valid = 1'b0; pwrup_n = 1'b1;
    repeat (2) @(negedge clk);

    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk(wiper_pos == 0 && !nv_busy, "R9 async reset", wiper_pos, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cmd(3, 1, 0);
    chk(rsp_data == INIT, "R9 registers reinitialised", rsp_data, INIT);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule